// File: doc/BRIEF.md
# Architected-to-Hex-Internal Operand Converter

This block sits at the head of a floating-point pipeline that computes on one hexadecimal-based internal number. It takes one 64-bit architected operand and a two-bit format select. It returns the same number in the internal form, which is a sign, a 14-bit exponent biased by 8192 and a 56-bit fraction in [0,1). The value is (-1)^s · 16^(e−8192) · f. Four source formats are accepted: short and long hexadecimal operands with a 7-bit exponent biased by 64, and short and long binary operands with 8- or 11-bit exponents biased by 127 or 1023.

Hex operands need no arithmetic. The exponent is widened by placing its top bit first and then seven copies of that bit inverted. For a binary operand, the exponent is split into a quotient by four and a remainder. The significand (the fraction with its implied one) is pre-shifted right by an amount set by that remainder. The sign-extension-encoded quotient is then incremented by one or two. The result is a hex-normalized number of equal value.

The converter also flags the special classes of binary operands so that later stages can steer execution. An optional output register, loaded when the input is valid, lets the block act as a pipeline stage.

Top module: `hexint_conv`

## Requirements
- R1: For a hex operand (format 00 short, 01 long), out_exp − 8192 equals the 7-bit operand exponent (bits 62:56) minus 64.
- R2: A hex short fraction (operand bits 55:32) lands in out_frac bits 55:32 and the lower 32 bits are zero. A hex long fraction (operand bits 55:0) passes unchanged.
- R3: For a normal binary operand (format 10 short: exponent bits 62:55, fraction 54:32; format 11 long: exponent bits 62:52, fraction 51:0), let u = biased exponent − bias and u = 4a + b with 0 ≤ b ≤ 3. Then out_exp = a + 1 + 8192 and out_frac = (1‖f) shifted left by 52 − F + b, where F is the fraction width.
- R4: A normal binary operand always yields a nonzero most significant hex digit (out_frac bits 55:52).
- R5: A binary operand with exponent field zero gets no implied one. It is treated as if its biased exponent were 1, so the R3 mapping applies with 1‖f replaced by 0‖f.
- R6: For binary operands the flags are set as follows: out_zero when exponent and fraction are both zero, out_denorm when the exponent is zero and the fraction nonzero, out_inf when the exponent is all ones and the fraction zero, and out_nan when the exponent is all ones and the fraction nonzero. At most one flag is set.
- R7: For hex operands, out_zero is set exactly when the fraction is zero, and out_inf, out_nan and out_denorm stay low.
- R8: out_sign equals operand bit 63 for every format.
- R9: The outputs register the conversion on the clock edge where in_valid is high, and out_valid follows in_valid one cycle later. While in_valid is low, all data outputs hold their values.
- R10: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present; loads the output stage |
| in_fmt | input | 2 | 00 hex short, 01 hex long, 10 binary short, 11 binary long |
| in_operand | input | 64 | Architected operand, short formats left-aligned |
| out_valid | output | 1 | Registered in_valid |
| out_sign | output | 1 | Internal sign |
| out_exp | output | 14 | Internal exponent, bias 8192 |
| out_frac | output | 56 | Internal fraction, hex normalized |
| out_zero | output | 1 | Operand is zero |
| out_inf | output | 1 | Binary infinity |
| out_nan | output | 1 | Binary NaN |
| out_denorm | output | 1 | Binary denormal |

## Verification
The bench sweeps every exponent of all four formats, including both ends of each range where the encoded quotient changes its top bit. A wrong complement run or a wrong increment would shift the value by a power of sixteen there. Each remainder value is covered, so a pre-shift that is off by one position, or a remainder 3 case given an increment of 1 instead of 2, shows up as an exponent or fraction miscompare against the value computed from u = 4a + b. The exponent-zero rows catch an implied one inserted into denormals and a wrong effective exponent. The all-ones rows with zero and nonzero fractions catch swapped infinity and NaN flags. A hold phase with in_valid low catches an output stage that loads on every clock.

// File: rtl/hexint_pkg.sv
package hexint_pkg;
   localparam int INT_EXP_W_DEF  = 14;
   localparam int INT_FRAC_W_DEF = 56;

   typedef enum logic [1:0] {
      FMT_HEX_SHORT = 2'b00,
      FMT_HEX_LONG  = 2'b01,
      FMT_BIN_SHORT = 2'b10,
      FMT_BIN_LONG  = 2'b11
   } fmt_e;

   typedef struct packed {
      logic zero;
      logic inf;
      logic nan;
      logic denorm;
   } cls_t;

   localparam int CLS_W = $bits(cls_t);
endpackage

// File: rtl/hexint_hex_widen.sv
module hexint_hex_widen
   import hexint_pkg::*;
#(
   parameter int ARCH_EXP_W = 7,
   parameter int FRAC_W     = 24,
   parameter int INT_EXP_W  = 14,
   parameter int INT_FRAC_W = 56
) (
   input  logic [ARCH_EXP_W-1:0] arch_exp,
   input  logic [FRAC_W-1:0]     arch_frac,
   output logic [INT_EXP_W-1:0]  int_exp,
   output logic [INT_FRAC_W-1:0] int_frac,
   output cls_t                  cls
);
   localparam int FILL_W = INT_EXP_W - ARCH_EXP_W;
   localparam int PAD_W  = INT_FRAC_W - FRAC_W;

   generate
      if (ARCH_EXP_W < 2 || FILL_W < 1) begin : g_bad_exp
         $error("hexint_hex_widen: internal exponent must be wider than architected");
      end
      if (PAD_W < 0) begin : g_bad_frac
         $error("hexint_hex_widen: fraction wider than internal fraction");
      end
   endgenerate

   // Range expansion: top bit, then its complement replicated, then the low bits.
   logic exp_top;
   assign exp_top = arch_exp[ARCH_EXP_W-1];
   assign int_exp = {exp_top, {FILL_W{~exp_top}}, arch_exp[ARCH_EXP_W-2:0]};

   generate
      if (PAD_W == 0) begin : g_frac_full
         assign int_frac = arch_frac;
      end else begin : g_frac_pad
         assign int_frac = {arch_frac, {PAD_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      cls        = '0;
      cls.zero   = (arch_frac == '0);
   end
endmodule

// File: rtl/hexint_bin_map.sv
module hexint_bin_map
   import hexint_pkg::*;
#(
   parameter int EXP_W      = 8,
   parameter int FRAC_W     = 23,
   parameter int INT_EXP_W  = 14,
   parameter int INT_FRAC_W = 56
) (
   input  logic [EXP_W-1:0]      arch_exp,
   input  logic [FRAC_W-1:0]     arch_frac,
   output logic [INT_EXP_W-1:0]  int_exp,
   output logic [INT_FRAC_W-1:0] int_frac,
   output cls_t                  cls
);
   localparam int SIG_W  = FRAC_W + 1;
   localparam int TAIL_W = INT_FRAC_W - SIG_W;
   localparam int Q_W    = EXP_W - 2;
   localparam int FILL_W = INT_EXP_W - Q_W;
   localparam logic [INT_EXP_W-1:0] INC_ONE = INT_EXP_W'(1);
   localparam logic [INT_EXP_W-1:0] INC_TWO = INT_EXP_W'(2);
   localparam logic [EXP_W-1:0]     EXP_MIN = EXP_W'(1);

   generate
      if (EXP_W < 4 || FILL_W < 1) begin : g_bad_exp
         $error("hexint_bin_map: exponent width out of range");
      end
      if (TAIL_W < 3) begin : g_bad_frac
         $error("hexint_bin_map: significand needs three spare bits for hex alignment");
      end
   endgenerate

   // field classification
   logic exp_zero, exp_ones, frac_zero;
   assign exp_zero  = (arch_exp == '0);
   assign exp_ones  = &arch_exp;
   assign frac_zero = (arch_frac == '0);

   always_comb begin
      cls.zero   = exp_zero & frac_zero;
      cls.denorm = exp_zero & ~frac_zero;
      cls.inf    = exp_ones & frac_zero;
      cls.nan    = exp_ones & ~frac_zero;
   end

   // denormals behave as biased exponent 1 without the leading one
   logic [EXP_W-1:0] eff_exp;
   logic [1:0]       rem4;
   logic [Q_W-1:0]   quot4;
   assign eff_exp = exp_zero ? EXP_MIN : arch_exp;
   assign rem4    = eff_exp[1:0];
   assign quot4   = eff_exp[EXP_W-1:2];

   // fraction: significand top-aligned, then moved right by (2 - rem4) mod 4
   logic [SIG_W-1:0]      sig;
   logic [INT_FRAC_W-1:0] sig_top;
   logic [1:0]            rshift;
   assign sig     = {~exp_zero, arch_frac};
   assign sig_top = {sig, {TAIL_W{1'b0}}};
   assign rshift  = 2'd2 - rem4;
   assign int_frac = sig_top >> rshift;

   // exponent: encoded quotient plus one, or plus two when the remainder is three
   logic [INT_EXP_W-1:0] q_enc;
   assign q_enc   = {quot4[Q_W-1], {FILL_W{~quot4[Q_W-1]}}, quot4[Q_W-2:0]};
   assign int_exp = q_enc + ((rem4 == 2'd3) ? INC_TWO : INC_ONE);
endmodule

// File: rtl/hexint_out_stage.sv
module hexint_out_stage #(
   parameter int DATA_W  = 75,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_o <= 1'b0;
               data_o  <= '0;
            end else begin
               valid_o <= valid_i;
               if (valid_i) data_o <= data_i;
            end
         end
      end else begin : g_comb
         assign valid_o = valid_i;
         assign data_o  = data_i;
      end
   endgenerate
endmodule

// File: rtl/hexint_conv.sv
module hexint_conv
   import hexint_pkg::*;
#(
   parameter int OPND_W      = 64,
   parameter int INT_EXP_W   = INT_EXP_W_DEF,
   parameter int INT_FRAC_W  = INT_FRAC_W_DEF,
   parameter int HEX_EXP_W   = 7,
   parameter int HS_FRAC_W   = 24,
   parameter int HL_FRAC_W   = 56,
   parameter int BS_EXP_W    = 8,
   parameter int BS_FRAC_W   = 23,
   parameter int BL_EXP_W    = 11,
   parameter int BL_FRAC_W   = 52,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [1:0]            in_fmt,
   input  logic [OPND_W-1:0]     in_operand,
   output logic                  out_valid,
   output logic                  out_sign,
   output logic [INT_EXP_W-1:0]  out_exp,
   output logic [INT_FRAC_W-1:0] out_frac,
   output logic                  out_zero,
   output logic                  out_inf,
   output logic                  out_nan,
   output logic                  out_denorm
);
   localparam int SIGN_POS = OPND_W - 1;
   localparam int EXP_TOP  = OPND_W - 2;
   localparam int DATA_W   = 1 + INT_EXP_W + INT_FRAC_W + CLS_W;
   localparam int INT_BIAS = 1 << (INT_EXP_W - 1);
   localparam int HEX_BIAS = 1 << (HEX_EXP_W - 1);

   generate
      if (1 + HEX_EXP_W + HL_FRAC_W != OPND_W || 1 + BL_EXP_W + BL_FRAC_W != OPND_W) begin : g_bad_long
         $error("hexint_conv: long formats must fill the operand");
      end
      if (1 + BS_EXP_W + BS_FRAC_W > OPND_W || 1 + HEX_EXP_W + HS_FRAC_W > OPND_W) begin : g_bad_short
         $error("hexint_conv: short formats exceed the operand");
      end
   endgenerate

   // ---------------- per-format converters ----------------
   logic [INT_EXP_W-1:0]  hs_exp, hl_exp, bs_exp, bl_exp;
   logic [INT_FRAC_W-1:0] hs_frac, hl_frac, bs_frac, bl_frac;
   cls_t                  hs_cls, hl_cls, bs_cls, bl_cls;

   hexint_hex_widen #(
      .ARCH_EXP_W (HEX_EXP_W), .FRAC_W (HS_FRAC_W),
      .INT_EXP_W  (INT_EXP_W), .INT_FRAC_W (INT_FRAC_W)
   ) u_hex_short (
      .arch_exp  (in_operand[EXP_TOP -: HEX_EXP_W]),
      .arch_frac (in_operand[EXP_TOP-HEX_EXP_W -: HS_FRAC_W]),
      .int_exp   (hs_exp),
      .int_frac  (hs_frac),
      .cls       (hs_cls)
   );

   hexint_hex_widen #(
      .ARCH_EXP_W (HEX_EXP_W), .FRAC_W (HL_FRAC_W),
      .INT_EXP_W  (INT_EXP_W), .INT_FRAC_W (INT_FRAC_W)
   ) u_hex_long (
      .arch_exp  (in_operand[EXP_TOP -: HEX_EXP_W]),
      .arch_frac (in_operand[HL_FRAC_W-1:0]),
      .int_exp   (hl_exp),
      .int_frac  (hl_frac),
      .cls       (hl_cls)
   );

   hexint_bin_map #(
      .EXP_W     (BS_EXP_W),  .FRAC_W     (BS_FRAC_W),
      .INT_EXP_W (INT_EXP_W), .INT_FRAC_W (INT_FRAC_W)
   ) u_bin_short (
      .arch_exp  (in_operand[EXP_TOP -: BS_EXP_W]),
      .arch_frac (in_operand[EXP_TOP-BS_EXP_W -: BS_FRAC_W]),
      .int_exp   (bs_exp),
      .int_frac  (bs_frac),
      .cls       (bs_cls)
   );

   hexint_bin_map #(
      .EXP_W     (BL_EXP_W),  .FRAC_W     (BL_FRAC_W),
      .INT_EXP_W (INT_EXP_W), .INT_FRAC_W (INT_FRAC_W)
   ) u_bin_long (
      .arch_exp  (in_operand[EXP_TOP -: BL_EXP_W]),
      .arch_frac (in_operand[BL_FRAC_W-1:0]),
      .int_exp   (bl_exp),
      .int_frac  (bl_frac),
      .cls       (bl_cls)
   );

   // ---------------- format select ----------------
   fmt_e                  fmt;
   logic [INT_EXP_W-1:0]  nxt_exp;
   logic [INT_FRAC_W-1:0] nxt_frac;
   cls_t                  nxt_cls;
   assign fmt = fmt_e'(in_fmt);

   always_comb begin
      unique case (fmt)
         FMT_HEX_SHORT: begin nxt_exp = hs_exp; nxt_frac = hs_frac; nxt_cls = hs_cls; end
         FMT_HEX_LONG:  begin nxt_exp = hl_exp; nxt_frac = hl_frac; nxt_cls = hl_cls; end
         FMT_BIN_SHORT: begin nxt_exp = bs_exp; nxt_frac = bs_frac; nxt_cls = bs_cls; end
         default:       begin nxt_exp = bl_exp; nxt_frac = bl_frac; nxt_cls = bl_cls; end
      endcase
   end

   // ---------------- output stage ----------------
   logic [DATA_W-1:0] stage_d, stage_q;
   assign stage_d = {in_operand[SIGN_POS], nxt_exp, nxt_frac, nxt_cls};

   hexint_out_stage #(.DATA_W (DATA_W), .REG_OUT (REG_OUT)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (in_valid),
      .data_i  (stage_d),
      .valid_o (out_valid),
      .data_o  (stage_q)
   );

   cls_t out_cls;
   assign {out_sign, out_exp, out_frac, out_cls} = stage_q;
   assign out_zero   = out_cls.zero;
   assign out_inf    = out_cls.inf;
   assign out_nan    = out_cls.nan;
   assign out_denorm = out_cls.denorm;

   // ---------------- assertions ----------------
   AST_HEX_EXP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_fmt[1]) |->
      (int'(nxt_exp) - INT_BIAS == int'(in_operand[EXP_TOP -: HEX_EXP_W]) - HEX_BIAS)); // R1

   AST_BIN_LEAD_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt[1] && (nxt_cls == '0)) |->
      (nxt_frac[INT_FRAC_W-1 -: 4] != 4'd0)); // R4

   AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> $onehot0(nxt_cls)); // R6

   AST_HEX_NO_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_fmt[1]) |-> !(nxt_cls.inf || nxt_cls.nan || nxt_cls.denorm)); // R7

   generate
      if (REG_OUT) begin : g_stage_checks
         AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R9

         AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(out_exp) && $stable(out_frac))); // R9

         AST_SIGN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (out_sign == $past(in_operand[SIGN_POS]))); // R8
      end
   endgenerate
endmodule

// File: tb/hexint_conv_tb.sv
module hexint_conv_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_fmt = 2'b00;
   logic [63:0] in_operand = '0;
   logic        out_valid, out_sign, out_zero, out_inf, out_nan, out_denorm;
   logic [13:0] out_exp;
   logic [55:0] out_frac;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

   always #2 clk = ~clk;

   hexint_conv u_dut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_fmt (in_fmt),
      .in_operand (in_operand), .out_valid (out_valid), .out_sign (out_sign),
      .out_exp (out_exp), .out_frac (out_frac), .out_zero (out_zero),
      .out_inf (out_inf), .out_nan (out_nan), .out_denorm (out_denorm)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h (fmt %0d op %h)",
                  req, what, act, exp, in_fmt, in_operand);
      end
   endtask

   function automatic logic [63:0] next_rand();
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 7);
      lfsr = lfsr ^ (lfsr << 17);
      return lfsr;
   endfunction

   // drive one operand, then compare outputs one clock later
   task automatic run_vec(input logic [1:0] fmt, input logic [63:0] op);
      int          ew, fw, bias, be, eff, ub, a, b;
      logic [63:0] f, e_frac;
      int          e_exp;
      bit          z, inf_x, nan_x, den, chk_val;
      z = 0; inf_x = 0; nan_x = 0; den = 0; chk_val = 1;
      if (!fmt[1]) begin
         be = int'(op[62:56]);
         f  = fmt[0] ? {8'd0, op[55:0]} : {40'd0, op[55:32]};
         e_exp  = be - 64 + 8192;
         e_frac = fmt[0] ? f : (f << 32);
         z = (f == 0);
      end else begin
         ew   = fmt[0] ? 11 : 8;
         fw   = fmt[0] ? 52 : 23;
         bias = (1 << (ew - 1)) - 1;
         be   = fmt[0] ? int'(op[62:52]) : int'(op[62:55]);
         f    = fmt[0] ? {12'd0, op[51:0]} : {41'd0, op[54:32]};
         z     = (be == 0) && (f == 0);
         den   = (be == 0) && (f != 0);
         inf_x = (be == (1 << ew) - 1) && (f == 0);
         nan_x = (be == (1 << ew) - 1) && (f != 0);
         chk_val = !(inf_x || nan_x);
         eff = (be == 0) ? 1 : be;
         ub  = eff - bias;
         a   = ((ub + 4096) >> 2) - 1024;
         b   = (ub + 4096) & 3;
         e_exp  = a + 1 + 8192;
         e_frac = (((be != 0) ? (64'd1 << fw) : 64'd0) | f) << (52 - fw + b);
      end
      @(negedge clk);
      in_valid   = 1'b1;
      in_fmt     = fmt;
      in_operand = op;
      @(negedge clk);
      check("R8", "sign", {63'd0, out_sign}, {63'd0, op[63]});
      check("R9", "valid", {63'd0, out_valid}, 64'd1);
      if (!fmt[1]) begin
         check("R1", "exponent", {50'd0, out_exp}, 64'(e_exp));
         check("R2", "fraction", {8'd0, out_frac}, e_frac);
         check("R7", "flags", {60'd0, out_zero, out_inf, out_nan, out_denorm},
               {60'd0, z, 3'b000});
      end else begin
         check("R6", "flags", {60'd0, out_zero, out_inf, out_nan, out_denorm},
               {60'd0, z, inf_x, nan_x, den});
         if (chk_val) begin
            if (be == 0) begin
               check("R5", "exponent", {50'd0, out_exp}, 64'(e_exp));
               check("R5", "fraction", {8'd0, out_frac}, e_frac);
            end else begin
               check("R3", "exponent", {50'd0, out_exp}, 64'(e_exp));
               check("R3", "fraction", {8'd0, out_frac}, e_frac);
               check("R4", "lead digit nonzero", {63'd0, (out_frac[55:52] != 0)}, 64'd1);
            end
         end
      end
   endtask

   initial begin : watchdog
      #(4 * 190000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [63:0] fr;
      logic [13:0] held_exp;
      logic [55:0] held_frac;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", "reset outputs",
            {out_valid, out_sign, out_zero, out_inf, out_nan, out_denorm, 58'd0}, 64'd0);
      check("R10", "reset exp/frac", {out_exp, out_frac} == 70'd0 ? 64'd0 : 64'd1, 64'd0);
      rst_n = 1'b1;

      // hex formats: every exponent, several fractions
      for (int fm = 0; fm < 2; fm++) begin
         for (int e = 0; e < 128; e++) begin
            for (int k = 0; k < 4; k++) begin
               fr = (k == 0) ? 64'd0 : (k == 1) ? 64'd1 :
                    (k == 2) ? 64'h00FF_FFFF_FFFF_FFFF : next_rand();
               if (fm == 0) fr = fr & 64'h0000_0000_00FF_FFFF;
               else         fr = fr & 64'h00FF_FFFF_FFFF_FFFF;
               run_vec(2'(fm), {1'(e + k), 7'(e),
                  (fm == 0) ? {fr[23:0], 32'h0} : fr[55:0]});
            end
         end
      end
      // binary short: every exponent
      for (int e = 0; e < 256; e++) begin
         for (int k = 0; k < 5; k++) begin
            fr = (k == 0) ? 64'd0 : (k == 1) ? 64'd1 : (k == 2) ? 64'h7F_FFFF :
                 (k == 3) ? 64'h40_0000 : (next_rand() & 64'h7F_FFFF);
            run_vec(2'b10, {1'(e ^ k), 8'(e), fr[22:0], 32'h0});
         end
      end
      // binary long: every exponent
      for (int e = 0; e < 2048; e++) begin
         for (int k = 0; k < 4; k++) begin
            fr = (k == 0) ? 64'd0 : (k == 1) ? 64'd1 :
                 (k == 2) ? 64'h000F_FFFF_FFFF_FFFF : (next_rand() & 64'h000F_FFFF_FFFF_FFFF);
            run_vec(2'b11, {1'(e + k), 11'(e), fr[51:0]});
         end
      end

      // R9: idle cycles hold the last result
      held_exp  = out_exp;
      held_frac = out_frac;
      @(negedge clk);
      in_valid   = 1'b0;
      in_fmt     = 2'b00;
      in_operand = 64'hC1AB_CDEF_0123_4567;
      @(negedge clk);
      check("R9", "idle valid", {63'd0, out_valid}, 64'd0);
      check("R9", "idle exp hold", {50'd0, out_exp}, {50'd0, held_exp});
      check("R9", "idle frac hold", {8'd0, out_frac}, {8'd0, held_frac});

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule